// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits just after the action-qualifier stage of a PWM channel. It turns one qualified PWM waveform into a pair of gate-drive outputs, A and B. A rising-edge delay holds back output A's turn-on edge. A falling-edge delay holds back output B's turn-off edge. A polarity field can invert either delayed path, which gives the active-high complementary pair used to drive a half bridge. A mode field lets each output take either the delayed path or the plain registered input.

The control word and both delay values are double-buffered. Each of the three registers has its own shadow-enable input. With shadow enabled, writes land in a shadow copy. That copy moves to the active copy only on an external load strobe, so a change of mode, polarity and delay takes effect on one clock edge. This lets output B be bypassed and later put back on the delay path without a stray pulse in between. With shadow disabled, a write takes effect on the next clock edge. The delay registers can take their load from a counter-equals-zero pulse instead of the strobe. The control register ignores that pulse.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is asserted, and after it is released with the input low, both outputs are low. After reset, the active control word is 0 and both delays are 0.
- R2: Control bit 1 set routes output A through the rising-edge delay path. With delay N, A rises N+1 cycles after the input is first sampled high and falls 1 cycle after the input is first sampled low.
- R3: Control bit 0 set routes output B through the falling-edge delay path. With delay N, B falls N+1 cycles after the input is first sampled low and rises 1 cycle after the input is first sampled high.
- R4: On a delayed path, an input pulse sampled on N or fewer consecutive cycles is absorbed when the delay is N, and that output does not toggle.
- R5: Control bit 2 inverts the delayed A path and control bit 3 inverts the delayed B path. Control value 11 (binary 1011) gives active-high complementary outputs: B low while the input is high, B high while it is low.
- R6: An output whose mode bit is clear is the input registered once, with no delay and no inversion.
- R7: With control value 11, out_a and out_b are never high in the same cycle.
- R8: For a register whose shadow enable is set, a write changes nothing at the outputs until a load occurs. On the load edge, the shadow value becomes active.
- R9: A write in the same cycle as a load goes to the shadow copy. The load moves the previous shadow value, and the new write needs a later load.
- R10: For a register whose shadow enable is clear, a write is active on the next clock edge.
- R11: With dly_load_on_zero set, the delay registers load on ctr_zero and ignore load_strobe. The control register always loads only on load_strobe.
- R12: Write select 0 addresses the control word (data bits 3:0), select 1 the rising-edge delay, select 2 the falling-edge delay, and select 3 nothing. Shadow-enable bit 0 belongs to the control word, bit 1 to the rising-edge delay and bit 2 to the falling-edge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_in | input | 1 | Qualified PWM waveform |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select for the write |
| cfg_wr_data | input | DLY_W | Write data |
| cfg_shadow_en | input | 3 | Per-register shadow enable |
| dly_load_on_zero | input | 1 | Delay registers load on ctr_zero instead of load_strobe |
| ctr_zero | input | 1 | Counter-equals-zero pulse from the time base |
| load_strobe | input | 1 | External shadow-to-active load strobe |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |

## Verification
The bench measures the edge-to-edge latency of each output in cycles, so a delay counter that is off by one (counting N-1 or N+1 cycles) is caught. It also catches a counter that is not cleared when the input returns. The bench sends pulses of exactly the delay length and of one cycle more. A generator that lets a short pulse through, or swallows one a cycle too long, fails there. The shadow tests write and load in the same cycle to catch a design that forwards the new write past the shadow. They also pulse ctr_zero with a pending control change to catch a control register that loads on the wrong event. In complementary mode, a monitor watches for A and B high together, which is the shoot-through a wrong polarity or path pairing would cause.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

  // Register select codes on the write port.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_NONE = 2'd3
  } db_sel_e;

  localparam int CTRL_W = 4;

  // Control word: [3] invert B path, [2] invert A path,
  // [1] A uses delay path, [0] B uses delay path.
  typedef struct packed {
    logic inv_b;
    logic inv_a;
    logic dly_a;
    logic dly_b;
  } db_ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_AHC_BOTH = 4'b1011;

endpackage

// File: rtl/pwm_db_shadow.sv
module pwm_db_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         shadow_mode,
  input  logic         load,
  output logic [W-1:0] active_o
);

  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] active_q, active_d;
  logic         shadow_ce, active_ce;

  // Next-state: shadow always takes writes; active takes either the
  // shadow copy on load (buffered) or the write data (immediate).
  always_comb begin
    shadow_ce = wr_en;
    shadow_d  = wr_data;
    if (shadow_mode) begin
      active_ce = load;
      active_d  = shadow_q;
    end else begin
      active_ce = wr_en;
      active_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shadow_ce) shadow_q <= shadow_d;
      if (active_ce) active_q <= active_d;
    end
  end

  assign active_o = active_q;

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mode && !load) |=> $stable(active_q));

  // R9
  load_old_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mode && load) |=> (active_q == $past(shadow_q)));

  // R10
  immediate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_mode && wr_en) |=> (active_q == $past(wr_data)));

endmodule

// File: rtl/pwm_db_edge.sv
module pwm_db_edge #(
  parameter int W        = 8,
  parameter bit SLOW_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         x,
  input  logic [W-1:0] dly,
  output logic         y
);

  logic         y_q, y_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         agree, fast_edge, window_done;

  always_comb begin
    agree       = (x == y_q);
    fast_edge   = (x != SLOW_VAL);
    window_done = (cnt_q >= dly);
    y_d   = y_q;
    cnt_d = cnt_q;
    if (agree) begin
      cnt_d = '0;
    end else if (fast_edge || window_done) begin
      y_d   = x;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      y_q   <= y_d;
      cnt_q <= cnt_d;
    end
  end

  assign y = y_q;

  // R2 R3
  fast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x != SLOW_VAL) |=> (y_q != SLOW_VAL));

  // R4
  slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q != SLOW_VAL && x == SLOW_VAL && cnt_q < dly) |=> (y_q != SLOW_VAL));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_db_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_wr_sel,
  input  logic [DLY_W-1:0] cfg_wr_data,
  input  logic [2:0]       cfg_shadow_en,
  input  logic             dly_load_on_zero,
  input  logic             ctr_zero,
  input  logic             load_strobe,
  output logic             out_a,
  output logic             out_b
);

  localparam int NUM_PATH = 2;

  logic                  ctrl_wr;
  logic [CTRL_W-1:0]     ctrl_raw;
  db_ctrl_t              ctrl;
  logic                  dly_load;
  logic [NUM_PATH-1:0]   dly_wr;
  logic [NUM_PATH-1:0]   path_y;
  logic [DLY_W-1:0]      dly_act [NUM_PATH];
  logic                  in_q;
  logic                  path_a, path_b;

  // Write decode and load source.
  always_comb begin
    ctrl_wr  = cfg_wr_en && (cfg_wr_sel == SEL_CTRL);
    dly_load = dly_load_on_zero ? ctr_zero : load_strobe;
  end

  pwm_db_shadow #(.W(CTRL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ctrl_wr),
    .wr_data     (cfg_wr_data[CTRL_W-1:0]),
    .shadow_mode (cfg_shadow_en[0]),
    .load        (load_strobe),
    .active_o    (ctrl_raw)
  );

  assign ctrl = db_ctrl_t'(ctrl_raw);

  // Path 0: rising-edge delay (slow to 1). Path 1: falling-edge delay (slow to 0).
  for (genvar g = 0; g < NUM_PATH; g++) begin : g_path
    localparam logic [1:0] SEL_CODE = (g == 0) ? SEL_RISE : SEL_FALL;

    assign dly_wr[g] = cfg_wr_en && (cfg_wr_sel == SEL_CODE);

    pwm_db_shadow #(.W(DLY_W)) u_dly (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (dly_wr[g]),
      .wr_data     (cfg_wr_data),
      .shadow_mode (cfg_shadow_en[g+1]),
      .load        (dly_load),
      .active_o    (dly_act[g])
    );

    pwm_db_edge #(.W(DLY_W), .SLOW_VAL((g == 0) ? 1'b1 : 1'b0)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (pwm_in),
      .dly   (dly_act[g]),
      .y     (path_y[g])
    );
  end

  // Bypass path register, aligned with the delay path latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= pwm_in;
  end

  // Polarity and output selection.
  always_comb begin
    path_a = path_y[0] ^ ctrl.inv_a;
    path_b = path_y[1] ^ ctrl.inv_b;
    out_a  = ctrl.dly_a ? path_a : in_q;
    out_b  = ctrl.dly_b ? path_b : in_q;
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_raw == CTRL_AHC_BOTH) |-> !(out_a && out_b));

  // R11
  ctrl_zero_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shadow_en[0] && !load_strobe) |=> $stable(ctrl_raw));

endmodule

// File: tb/tb_pwm_deadband.sv
`timescale 1ns/1ps
module tb_pwm_deadband;

  localparam int DW = 10;

  logic          clk;
  logic          rst_n;
  logic          pwm_in;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wr_sel;
  logic [DW-1:0] cfg_wr_data;
  logic [2:0]    cfg_shadow_en;
  logic          dly_load_on_zero;
  logic          ctr_zero;
  logic          load_strobe;
  logic          out_a;
  logic          out_b;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;
  bit mon_en = 0;

  pwm_deadband #(.DLY_W(DW)) dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .pwm_in           (pwm_in),
    .cfg_wr_en        (cfg_wr_en),
    .cfg_wr_sel       (cfg_wr_sel),
    .cfg_wr_data      (cfg_wr_data),
    .cfg_shadow_en    (cfg_shadow_en),
    .dly_load_on_zero (dly_load_on_zero),
    .ctr_zero         (ctr_zero),
    .load_strobe      (load_strobe),
    .out_a            (out_a),
    .out_b            (out_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (mon_en && out_a && out_b) overlaps++;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, int data);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_sel  = sel;
    cfg_wr_data = DW'(data);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load_strobe = 1'b1;
    @(negedge clk); load_strobe = 1'b0;
  endtask

  task automatic pulse_zero();
    @(negedge clk); ctr_zero = 1'b1;
    @(negedge clk); ctr_zero = 1'b0;
  endtask

  // Drive the input to val and record the first cycle each output reaches its target.
  task automatic meas(logic val, logic ta, logic tb, int ea, int eb, string tag_a, string tag_b);
    int fa = 0;
    int fb = 0;
    @(negedge clk);
    pwm_in = val;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (fa == 0 && out_a == ta) fa = i;
      if (fb == 0 && out_b == tb) fb = i;
    end
    check(tag_a, fa, ea);
    check(tag_b, fb, eb);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwm_in = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = 2'd3;
    cfg_wr_data = '0; cfg_shadow_en = 3'b000; dly_load_on_zero = 1'b0;
    ctr_zero = 1'b0; load_strobe = 1'b0;
    settle(4);
    check("R1 out_a in reset", int'(out_a), 0);
    check("R1 out_b in reset", int'(out_b), 0);
    rst_n = 1'b1;
    settle(2);
    check("R1 out_a after reset", int'(out_a), 0);
    check("R1 out_b after reset", int'(out_b), 0);
  endtask

  task automatic t_immediate();
    wr(2'd1, 3);
    wr(2'd2, 5);
    wr(2'd0, 11);
    check("R10 immediate ctrl write visible next cycle", int'(out_b), 1);
    wr(2'd0, 3);
    check("R10 immediate ctrl rewrite", int'(out_b), 0);
    meas(1'b1, 1'b1, 1'b1, 4, 1, "R12 R2 A rise delayed", "R3 B rise fast");
    meas(1'b0, 1'b0, 1'b0, 1, 6, "R2 A fall fast", "R12 R3 B fall delayed");
  endtask

  task automatic t_pulses();
    int seen;
    seen = 0;
    @(negedge clk); pwm_in = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (out_a) seen = 1; end
    pwm_in = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (out_a) seen = 1; end
    check("R4 high pulse equal to delay absorbed", seen, 0);
    seen = 0;
    @(negedge clk); pwm_in = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (out_a) seen = 1; end
    pwm_in = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (out_a) seen = 1; end
    check("R4 high pulse one longer passes", seen, 1);
    @(negedge clk); pwm_in = 1'b1;
    settle(10);
    seen = 0;
    @(negedge clk); pwm_in = 1'b0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (!out_b) seen = 1; end
    pwm_in = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!out_b) seen = 1; end
    check("R4 low pulse equal to delay absorbed", seen, 0);
    @(negedge clk); pwm_in = 1'b0;
    settle(12);
  endtask

  task automatic t_complementary();
    wr(2'd0, 11);
    overlaps = 0;
    mon_en = 1'b1;
    meas(1'b1, 1'b1, 1'b0, 4, 1, "R5 AHC A rise", "R5 AHC B low on input high");
    meas(1'b0, 1'b0, 1'b1, 1, 6, "R5 AHC A fall", "R5 AHC B high after fall delay");
    mon_en = 1'b0;
    check("R7 no cycle with both outputs high", overlaps, 0);
  endtask

  task automatic t_bypass();
    wr(2'd0, 10);
    meas(1'b1, 1'b1, 1'b1, 4, 1, "R6 A still delayed", "R6 B bypass rise");
    meas(1'b0, 1'b0, 1'b0, 1, 1, "R6 A fall", "R6 B bypass fall");
    settle(10);
  endtask

  task automatic t_shadow();
    @(negedge clk); cfg_shadow_en = 3'b111;
    wr(2'd0, 11);
    settle(3);
    check("R8 shadow write held", int'(out_b), 0);
    pulse_load();
    check("R8 load applies shadow", int'(out_b), 1);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 2'd0; cfg_wr_data = DW'(10); load_strobe = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; load_strobe = 1'b0;
    check("R9 same-cycle write not loaded", int'(out_b), 1);
    pulse_load();
    check("R9 next load takes write", int'(out_b), 0);
  endtask

  task automatic t_load_source();
    @(negedge clk); dly_load_on_zero = 1'b1;
    wr(2'd1, 6);
    pulse_load();
    meas(1'b1, 1'b1, 1'b1, 4, 1, "R11 strobe ignored for delay", "R6 B bypass");
    meas(1'b0, 1'b0, 1'b0, 1, 1, "R2 A fall", "R6 B bypass fall");
    pulse_zero();
    meas(1'b1, 1'b1, 1'b1, 7, 1, "R11 zero loads delay", "R6 B bypass");
    meas(1'b0, 1'b0, 1'b0, 1, 1, "R2 A fall", "R6 B bypass fall");
    wr(2'd0, 11);
    pulse_zero();
    check("R11 ctrl ignores ctr_zero", int'(out_b), 0);
    pulse_load();
    check("R11 ctrl loads on strobe", int'(out_b), 1);
  endtask

  initial begin
    t_reset();
    t_immediate();
    t_pulses();
    t_complementary();
    t_bypass();
    t_shadow();
    t_load_source();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule